// File: doc/BRIEF.md
# Serial Sampling Converter Frame and Power-Mode Controller

This block is the digital back end of a sampling converter that is read over a three-wire serial link. A host lowers an active-low select line to take a sample and start a conversion, then toggles a serial clock; the block sends back a 16-bit word, one bit per falling clock edge, on a data line that is modelled as a data bit plus an output enable. The word starts with four zero bits, carries the result most significant bit first, and is filled with trailing zeros when the resolution (12, 10 or 8 bits, chosen by parameter) is narrower than the field.

The same select line also manages power. The number of serial-clock falling edges counted when select rises decides the next mode: a very early rise is treated as a glitch and changes nothing, a rise inside a middle window sends the block to sleep, and a late rise keeps it, or brings it back, awake. A frame that starts while asleep is a wake-up frame whose result field is blank. A track/hold status output shows when the sampling front end holds the input and when it tracks again.

All inputs are synchronised into a faster system clock and edge-detected, so the serial clock is never used as a clock. Every response appears three system-clock edges after the input change that causes it.

Top module: `sadc_frame_ctrl`

## Requirements
- R1: A select fall captures `sample_i`, sets `sdo_oe_o` high and drives a 0 as the first frame bit.
- R2: Each later serial-clock fall presents the next bit of the 16-bit word {4 zeros, result MSB first, zero padding}; the padding is 0, 2 or 4 bits for 12-, 10- or 8-bit resolution.
- R3: `sdo_oe_o` drops on the 16th serial-clock fall of a frame and stays low while select stays low.
- R4: A select rise before the 16th fall drops `sdo_oe_o` at once and aborts the frame.
- R5: A select rise after 2 to 9 falls (inclusive) makes `awake_o` 0 (sleep).
- R6: A select rise after 0 or 1 falls leaves `awake_o` unchanged; `awake_o` changes at no other time.
- R7: A select rise after 10 or more falls makes `awake_o` 1, whether the frame began awake or asleep.
- R8: A frame that begins with `awake_o` = 0 sends all-zero bits; if select rises before its 10th fall the block stays asleep, and the frame after a completed wake-up carries valid data.
- R9: `track_o` goes 0 at the select fall and returns to 1 on the serial-clock rise after the 13th fall (12- and 10-bit) or the 11th fall (8-bit).
- R10: In a frame begun asleep, `track_o` returns to 1 on the first serial-clock edge after the select fall; while asleep between frames `track_o` is 0, and after a select rise it equals the new `awake_o`.
- R11: Each frame carries the sample taken at its own select fall; changes of `sample_i` later in the frame do not reach `sdo_o`.
- R12: After reset `sdo_oe_o` = 0 and `awake_o` = `track_o` = 1 with the default parameter (0 and 0 when reset into sleep is chosen).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Active-low select from the host (asynchronous) |
| sclk_i | input | 1 | Serial clock from the host (asynchronous, idles high) |
| sample_i | input | RES_BITS | Parallel result from the converter stub |
| sdo_o | output | 1 | Serial data bit, 0 when not enabled |
| sdo_oe_o | output | 1 | Output enable of the serial data line |
| track_o | output | 1 | 1 = front end tracks, 0 = holds |
| awake_o | output | 1 | Power mode: 1 = normal, 0 = sleep |

## Verification
The select rise both ends the data output and settles the power mode in the same system-clock cycle, and in a wake-up frame the first serial-clock edge both advances the bit count and releases the hold. The bench raises select exactly at the boundary counts 1, 2, 9 and 10, and at 12 and 16, and after each rise samples the enable, the track status and the mode together against a model of the mode it keeps itself. Two instances of 12 and 8 bits run side by side on the same stimulus so that padding and the two hold-release edges are judged in the same sample.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

   typedef enum logic {
      MODE_SLEEP = 1'b0,
      MODE_AWAKE = 1'b1
   } pwr_mode_e;

   // Falling-edge count after which the hold is released on the next rise
   function automatic int unsigned hold_release_edge(input int unsigned res_bits);
      return (res_bits <= 8) ? 11 : 13;
   endfunction

   function automatic bit res_supported(input int unsigned res_bits);
      return (res_bits == 8) || (res_bits == 10) || (res_bits == 12);
   endfunction

endpackage

// File: rtl/sadc_in_sync.sv
module sadc_in_sync #(
   parameter int unsigned STAGES = 2,
   parameter bit          IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sadc_in_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= {STAGES{IDLE}};
         prev_q  <= IDLE;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_o =  chain_q[STAGES-1] & ~prev_q;
   assign fall_o = ~chain_q[STAGES-1] &  prev_q;

endmodule

// File: rtl/sadc_frame_shift.sv
module sadc_frame_shift #(
   parameter int unsigned RES_BITS   = 12,
   parameter int unsigned FRAME_BITS = 16,
   parameter int unsigned LEAD_ZEROS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic                blank_i,
   input  logic                shift_i,
   input  logic                stop_i,
   input  logic [RES_BITS-1:0] sample_i,
   output logic                sdo_o,
   output logic                oe_o
);

   localparam int PAD_BITS = int'(FRAME_BITS) - int'(LEAD_ZEROS) - int'(RES_BITS);

   logic [FRAME_BITS-1:0] word_w;
   logic [FRAME_BITS-1:0] frame_q;
   logic                  oe_q;

   generate
      if (PAD_BITS > 0) begin : g_padded
         assign word_w = {{LEAD_ZEROS{1'b0}}, sample_i, {PAD_BITS{1'b0}}};
      end else begin : g_full
         assign word_w = {{LEAD_ZEROS{1'b0}}, sample_i};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q <= '0;
         oe_q    <= 1'b0;
      end else if (load_i) begin
         frame_q <= blank_i ? '0 : word_w;
         oe_q    <= 1'b1;
      end else begin
         if (shift_i) begin
            frame_q <= {frame_q[FRAME_BITS-2:0], 1'b0};
         end
         if (stop_i) begin
            oe_q <= 1'b0;
         end
      end
   end

   assign sdo_o = oe_q & frame_q[FRAME_BITS-1];
   assign oe_o  = oe_q;

endmodule

// File: rtl/sadc_pwr_ctrl.sv
module sadc_pwr_ctrl
   import sadc_pkg::*;
#(
   parameter int unsigned RES_BITS       = 12,
   parameter int unsigned FRAME_BITS     = 16,
   parameter int unsigned PD_ENTRY_EDGE  = 2,
   parameter int unsigned PD_EXIT_EDGE   = 10,
   parameter bit          SLEEP_AT_RESET = 1'b0,
   localparam int unsigned CW            = $clog2(FRAME_BITS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_fall_i,
   input  logic          cs_rise_i,
   input  logic          sclk_fall_i,
   input  logic          sclk_rise_i,
   output logic          load_o,
   output logic          blank_o,
   output logic          shift_o,
   output logic          stop_o,
   output logic          track_o,
   output logic          awake_o,
   output logic          active_o,
   output logic [CW-1:0] cnt_o
);

   localparam logic [CW-1:0] LAST_CNT = CW'(FRAME_BITS - 1);
   localparam logic [CW-1:0] FULL_CNT = CW'(FRAME_BITS);
   localparam logic [CW-1:0] LO_CNT   = CW'(PD_ENTRY_EDGE);
   localparam logic [CW-1:0] HI_CNT   = CW'(PD_EXIT_EDGE);
   localparam logic [CW-1:0] TRK_CNT  = CW'(hold_release_edge(RES_BITS));
   localparam pwr_mode_e     RST_MODE = SLEEP_AT_RESET ? MODE_SLEEP : MODE_AWAKE;

   pwr_mode_e     mode_q;
   pwr_mode_e     mode_next;
   logic          active_q;
   logic          wake_frame_q;
   logic          track_q;
   logic [CW-1:0] cnt_q;
   logic          frame_end;

   // Mode chosen by where the select rise falls in the edge count
   always_comb begin
      mode_next = mode_q;
      if (cnt_q >= HI_CNT) begin
         mode_next = MODE_AWAKE;
      end else if (cnt_q >= LO_CNT) begin
         mode_next = MODE_SLEEP;
      end
   end

   assign frame_end = active_q & cs_rise_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q       <= RST_MODE;
         active_q     <= 1'b0;
         wake_frame_q <= 1'b0;
         track_q      <= (RST_MODE == MODE_AWAKE);
         cnt_q        <= '0;
      end else if (cs_fall_i) begin
         active_q     <= 1'b1;
         wake_frame_q <= (mode_q == MODE_SLEEP);
         track_q      <= 1'b0;
         cnt_q        <= '0;
      end else if (frame_end) begin
         active_q <= 1'b0;
         mode_q   <= mode_next;
         track_q  <= (mode_next == MODE_AWAKE);
      end else if (active_q) begin
         if (sclk_fall_i && (cnt_q < FULL_CNT)) begin
            cnt_q <= cnt_q + 1'b1;
         end
         if (wake_frame_q) begin
            if (sclk_fall_i || sclk_rise_i) begin
               track_q <= 1'b1;
            end
         end else if (sclk_rise_i && (cnt_q == TRK_CNT)) begin
            track_q <= 1'b1;
         end
      end
   end

   assign load_o   = cs_fall_i;
   assign blank_o  = (mode_q == MODE_SLEEP);
   assign shift_o  = active_q & ~cs_rise_i & sclk_fall_i & (cnt_q < LAST_CNT);
   assign stop_o   = frame_end | (active_q & sclk_fall_i & (cnt_q == LAST_CNT));
   assign track_o  = track_q;
   assign awake_o  = (mode_q == MODE_AWAKE);
   assign active_o = active_q;
   assign cnt_o    = cnt_q;

endmodule

// File: rtl/sadc_frame_ctrl.sv
module sadc_frame_ctrl
   import sadc_pkg::*;
#(
   parameter int unsigned RES_BITS       = 12,
   parameter int unsigned FRAME_BITS     = 16,
   parameter int unsigned LEAD_ZEROS     = 4,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned PD_ENTRY_EDGE  = 2,
   parameter int unsigned PD_EXIT_EDGE   = 10,
   parameter bit          SLEEP_AT_RESET = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n_i,
   input  logic                sclk_i,
   input  logic [RES_BITS-1:0] sample_i,
   output logic                sdo_o,
   output logic                sdo_oe_o,
   output logic                track_o,
   output logic                awake_o
);

   localparam int unsigned CW = $clog2(FRAME_BITS + 1);

   generate
      if (!res_supported(RES_BITS)) begin : g_bad_res
         $error("sadc_frame_ctrl: RES_BITS must be 8, 10 or 12");
      end
      if ((LEAD_ZEROS < 1) || (LEAD_ZEROS + RES_BITS > FRAME_BITS)) begin : g_bad_frame
         $error("sadc_frame_ctrl: lead zeros and result do not fit the frame");
      end
      if ((PD_ENTRY_EDGE >= PD_EXIT_EDGE) || (PD_EXIT_EDGE > FRAME_BITS)) begin : g_bad_window
         $error("sadc_frame_ctrl: power-down window is not ordered inside the frame");
      end
   endgenerate

   logic          cs_rise_w;
   logic          cs_fall_w;
   logic          sclk_rise_w;
   logic          sclk_fall_w;
   logic          load_w;
   logic          blank_w;
   logic          shift_w;
   logic          stop_w;
   logic          active_w;
   logic [CW-1:0] edge_cnt_w;

   sadc_in_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_cs_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (cs_n_i),
      .rise_o (cs_rise_w),
      .fall_o (cs_fall_w)
   );

   sadc_in_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sclk_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (sclk_i),
      .rise_o (sclk_rise_w),
      .fall_o (sclk_fall_w)
   );

   sadc_pwr_ctrl #(
      .RES_BITS       (RES_BITS),
      .FRAME_BITS     (FRAME_BITS),
      .PD_ENTRY_EDGE  (PD_ENTRY_EDGE),
      .PD_EXIT_EDGE   (PD_EXIT_EDGE),
      .SLEEP_AT_RESET (SLEEP_AT_RESET)
   ) u_pwr (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_fall_i   (cs_fall_w),
      .cs_rise_i   (cs_rise_w),
      .sclk_fall_i (sclk_fall_w),
      .sclk_rise_i (sclk_rise_w),
      .load_o      (load_w),
      .blank_o     (blank_w),
      .shift_o     (shift_w),
      .stop_o      (stop_w),
      .track_o     (track_o),
      .awake_o     (awake_o),
      .active_o    (active_w),
      .cnt_o       (edge_cnt_w)
   );

   sadc_frame_shift #(
      .RES_BITS   (RES_BITS),
      .FRAME_BITS (FRAME_BITS),
      .LEAD_ZEROS (LEAD_ZEROS)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_w),
      .blank_i  (blank_w),
      .shift_i  (shift_w),
      .stop_i   (stop_w),
      .sample_i (sample_i),
      .sdo_o    (sdo_o),
      .oe_o     (sdo_oe_o)
   );

endmodule

// File: rtl/sadc_frame_ctrl_chk.sv
module sadc_frame_ctrl_chk #(
   parameter int unsigned FRAME_BITS    = 16,
   parameter int unsigned PD_ENTRY_EDGE = 2,
   parameter int unsigned PD_EXIT_EDGE  = 10,
   parameter int unsigned CW            = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_fall,
   input logic          cs_rise,
   input logic          active,
   input logic [CW-1:0] cnt,
   input logic          sdo,
   input logic          sdo_oe,
   input logic          track,
   input logic          awake
);

   localparam logic [CW-1:0] FULL = CW'(FRAME_BITS);
   localparam logic [CW-1:0] LO   = CW'(PD_ENTRY_EDGE);
   localparam logic [CW-1:0] HI   = CW'(PD_EXIT_EDGE);

   p_first_bit_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall |=> (sdo_oe && !sdo));

   p_oe_off_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && (cnt == FULL)) |-> !sdo_oe);

   p_oe_off_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cs_rise) |=> !sdo_oe);

   p_enter_sleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cs_rise && (cnt >= LO) && (cnt < HI)) |=> !awake);

   p_glitch_keeps_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cs_rise && (cnt < LO)) |=> $stable(awake));

   p_mode_only_at_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(active && cs_rise) |=> $stable(awake));

   p_late_rise_awake_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cs_rise && (cnt >= HI)) |=> awake);

   p_hold_at_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall |=> !track);

endmodule

bind sadc_frame_ctrl sadc_frame_ctrl_chk #(
   .FRAME_BITS    (FRAME_BITS),
   .PD_ENTRY_EDGE (PD_ENTRY_EDGE),
   .PD_EXIT_EDGE  (PD_EXIT_EDGE),
   .CW            (CW)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_fall (cs_fall_w),
   .cs_rise (cs_rise_w),
   .active  (active_w),
   .cnt     (edge_cnt_w),
   .sdo     (sdo_o),
   .sdo_oe  (sdo_oe_o),
   .track   (track_o),
   .awake   (awake_o)
);

// File: tb/sadc_frame_ctrl_tb.sv
module sadc_frame_ctrl_tb;

   // kind: 0 enable, 1 data, 2 track, 3 mode; unit: 0 = 12-bit, 1 = 8-bit
   typedef struct {
      int    kind;
      int    unit;
      logic  val;
      string req;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sclk = 1'b1;
   logic [11:0] smp12 = '0;
   logic [7:0]  smp8  = '0;
   logic       sdo12, oe12, trk12, awk12;
   logic       sdo8, oe8, trk8, awk8;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;
   bit  model_awake = 1'b1;
   exp_t exp_q[$];
   event chk_ev;

   always #5 clk = ~clk;

   sadc_frame_ctrl #(.RES_BITS(12)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sample_i(smp12),
      .sdo_o(sdo12), .sdo_oe_o(oe12), .track_o(trk12), .awake_o(awk12)
   );

   sadc_frame_ctrl #(.RES_BITS(8)) u_dut8 (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sample_i(smp8),
      .sdo_o(sdo8), .sdo_oe_o(oe8), .track_o(trk8), .awake_o(awk8)
   );

   // Monitor: pops every queued expectation and compares it with the ports
   initial begin
      forever begin
         @(chk_ev);
         while (exp_q.size() > 0) begin
            exp_t e;
            logic act;
            e = exp_q.pop_front();
            case (e.kind)
               0: act = (e.unit == 0) ? oe12  : oe8;
               1: act = (e.unit == 0) ? sdo12 : sdo8;
               2: act = (e.unit == 0) ? trk12 : trk8;
               default: act = (e.unit == 0) ? awk12 : awk8;
            endcase
            n_checks++;
            if (act !== e.val) begin
               n_fail++;
               $display("FAIL %s unit%0d kind%0d: got %b expected %b at %0t",
                        e.req, e.unit, e.kind, act, e.val, $time);
            end
         end
      end
   end

   task automatic push(input int kind, input int unit, input logic val, input string req);
      exp_t e;
      e.kind = kind; e.unit = unit; e.val = val; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic expect_state(input logic oe, input logic d12, input logic d8,
                               input logic t12, input logic t8, input string oe_req,
                               input string d_req, input string t_req, input string m_req);
      push(0, 0, oe, oe_req);
      push(0, 1, oe, oe_req);
      if (oe) begin
         push(1, 0, d12, d_req);
         push(1, 1, d8, d_req);
      end
      push(2, 0, t12, t_req);
      push(2, 1, t8, t_req);
      push(3, 0, model_awake, m_req);
      push(3, 1, model_awake, m_req);
      -> chk_ev;
   endtask

   // Driver: one select-framed transfer with n_fall serial-clock falls
   task automatic run_frame(input int n_fall, input logic [11:0] s12, input logic [7:0] s8,
                            input bit change_sample, input string m_req);
      bit dummy;
      logic [15:0] w12, w8;
      string d_req, t_req;
      dummy = !model_awake;
      w12   = dummy ? 16'h0 : {4'h0, s12};
      w8    = dummy ? 16'h0 : {4'h0, s8, 4'h0};
      d_req = dummy ? "R8" : (change_sample ? "R11" : "R2");
      t_req = dummy ? "R10" : "R9";
      smp12 = s12;
      smp8  = s8;
      wait_cyc(4);
      cs_n = 1'b0;
      wait_cyc(8);
      expect_state(1'b1, w12[15], w8[15], 1'b0, 1'b0, "R1", "R1", "R9", "R6");
      if (change_sample) begin
         smp12 = ~s12;
         smp8  = ~s8;
      end
      for (int k = 1; k <= n_fall; k++) begin
         logic oe;
         oe   = (k < 16);
         sclk = 1'b0;
         wait_cyc(8);
         expect_state(oe, oe ? w12[15-k] : 1'b0, oe ? w8[15-k] : 1'b0,
                      dummy ? 1'b1 : (k >= 14), dummy ? 1'b1 : (k >= 12),
                      "R3", d_req, t_req, "R6");
         sclk = 1'b1;
         wait_cyc(8);
         expect_state(oe, oe ? w12[15-k] : 1'b0, oe ? w8[15-k] : 1'b0,
                      dummy ? 1'b1 : (k >= 13), dummy ? 1'b1 : (k >= 11),
                      "R3", d_req, t_req, "R6");
      end
      cs_n = 1'b1;
      wait_cyc(8);
      if (n_fall >= 10)     model_awake = 1'b1;
      else if (n_fall >= 2) model_awake = 1'b0;
      expect_state(1'b0, 1'b0, 1'b0, model_awake, model_awake, "R4", "R4", "R10", m_req);
      wait_cyc(4);
   endtask

   initial begin
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(2);
      expect_state(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R12", "R12", "R12", "R12");

      run_frame(16, 12'hA5C, 8'hB3, 1'b1, "R7");  // R11: sample changed mid-frame
      run_frame(16, 12'hFFF, 8'hFF, 1'b0, "R7");  // R2 all-ones word
      run_frame(12, 12'h001, 8'h01, 1'b0, "R7");  // R4 abort at 12, stays awake
      run_frame(1,  12'h3C3, 8'h5A, 1'b0, "R6");  // R6 glitch, mode kept
      run_frame(10, 12'h777, 8'h77, 1'b0, "R7");  // R7 boundary at 10
      run_frame(2,  12'h0F0, 8'h0F, 1'b0, "R5");  // R5 boundary at 2 -> sleep
      run_frame(1,  12'hABC, 8'hAB, 1'b0, "R6");  // R6 glitch while asleep
      run_frame(9,  12'hABC, 8'hAB, 1'b0, "R8");  // R8 wake aborted at 9
      run_frame(10, 12'hABC, 8'hAB, 1'b0, "R7");  // R7 wake completes at 10
      run_frame(16, 12'h123, 8'h45, 1'b0, "R8");  // R8 next frame valid
      run_frame(9,  12'h456, 8'h96, 1'b0, "R5");  // R5 boundary at 9
      run_frame(16, 12'h999, 8'h99, 1'b0, "R7");  // R10 full wake frame
      run_frame(16, 12'h800, 8'h80, 1'b0, "R7");  // R2 MSB position

      done = 1'b1;
      wait_cyc(2);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule